// File: doc/BRIEF.md
# Oscillator-Gated Reset and Register Initializer

This block controls power-on and software reset for the register bank of a small data converter. After power is applied it keeps the device in reset until an oscillator-started indication arrives. That indication is passed through a two-flop synchronizer. The block then waits a fixed number of oscillator cycles so the crystal can settle. For the whole hold, the serial port reset output stays asserted and the reset-valid flag is forced on. When the wait ends, the block enters command mode.

The bank holds four 24-bit registers: configuration, offset, gain and channel setup. On power-on reset and on software reset they are loaded with fixed defaults. Software starts a reset by setting the reset-system bit in the configuration register. The only way out of that reset is a configuration write with that bit cleared, and every other bit of that write is dropped. Reads are always allowed. A configuration read clears the sticky reset-valid flag.

Top module: `osc_rst_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises until the synchronized `osc_started` is seen, `busy` and `port_rst` are 1 and `cmd_mode` is 0.
- R2: After `osc_started` is raised between clock edges, `busy` and `port_rst` stay 1 through the following TERM_CNT+2 rising edges (default 2006). Both fall at the (TERM_CNT+3)th rising edge, and `cmd_mode` rises at that same edge.
- R3: Register addresses are 0 configuration, 1 offset, 2 gain and 3 channel setup. After power-on reset they read 0x000040, 0x000000, 0x400000 and 0x000000.
- R4: The reset-valid flag is configuration bit 6. It reads 1 throughout the power-on hold and settle, and reads in that period do not clear it.
- R5: A read returns its data on `rd_data` one cycle after `rd_en`. A configuration read outside the power-on hold returns the current reset-valid bit and then clears it, so the next read shows 0.
- R6: In command mode a write stores `wr_data` at `addr`. In configuration writes, bit 6 (reset-valid) is read-only and keeps its value.
- R7: In command mode, a configuration write with bit 7 (reset-system) set has two effects from the next cycle on. All registers take their defaults, with configuration reading 0x0000C0. `busy` is 1 while `port_rst` stays 0, because no settle wait is rerun.
- R8: While `busy` is 1, writes to offset, gain and channel setup, and configuration writes with bit 7 set, have no effect.
- R9: During software reset, a configuration write with bit 7 clear returns the block to command mode at the next cycle with bit 7 cleared. All other bits of that write are discarded, and a later write is needed to set them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| osc_started | input | 1 | Asynchronous oscillator-running indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wr_data | input | 24 | Write data |
| rd_data | output | 24 | Registered read data |
| busy | output | 1 | Device held in reset |
| port_rst | output | 1 | Serial port reset during power-on hold and settle |
| cmd_mode | output | 1 | Command mode reached |

## Verification
The assertions assume the following about the inputs:
- `osc_started` is raised only once after power-on reset and then stays high.
- A read and a write never target the configuration register in the same cycle.
- The strobes are single-cycle pulses driven between clock edges.

The bench keeps to these rules by using one task per transaction, each task occupying exactly one cycle. It raises the oscillator indication once, at a falling edge. The timing checks are placed using that known cycle count from the moment the indication rises.

// File: rtl/osc_rst_pkg.sv
package osc_rst_pkg;
    localparam int DW     = 24;
    localparam int AW     = 2;
    localparam int RV_BIT = 6;
    localparam int RS_BIT = 7;

    localparam logic [DW-1:0] CFG_DEF  = 24'h000040;
    localparam logic [DW-1:0] OFS_DEF  = 24'h000000;
    localparam logic [DW-1:0] GAIN_DEF = 24'h400000;
    localparam logic [DW-1:0] CHAN_DEF = 24'h000000;

    localparam logic [DW-1:0] RV_MASK = DW'(1) << RV_BIT;
    localparam logic [DW-1:0] RS_MASK = DW'(1) << RS_BIT;

    typedef enum logic [AW-1:0] {
        SEL_CFG  = 2'd0,
        SEL_OFS  = 2'd1,
        SEL_GAIN = 2'd2,
        SEL_CHAN = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SWRST  = 2'd2,
        ST_CMD    = 2'd3
    } rst_state_e;
endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb s_d.sh = din;
        end else begin : g_many
            always_comb s_d.sh = {s_q.sh[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.sh[STAGES-1];
endmodule

// File: rtl/osc_rst_timer.sv
module osc_rst_timer #(
    parameter int TERM_CNT = 2006,
    parameter int CNT_W    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(TERM_CNT);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!en)                 t_d.cnt = ONE;
        else if (t_q.cnt != TERM) t_d.cnt = t_q.cnt + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q.cnt <= ONE;
        else        t_q <= t_d;
    end

    assign done = en && (t_q.cnt == TERM);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= TERM);
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !done) |=> (t_q.cnt == $past(t_q.cnt) + ONE));
endmodule

// File: rtl/osc_rst_regs.sv
module osc_rst_regs
    import osc_rst_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_load,
    input  logic          sw_load,
    input  logic          rs_clr,
    input  logic          wr_ok,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] ofs;
        logic [DW-1:0] gain;
        logic [DW-1:0] chan;
        logic [DW-1:0] rd;
    } bank_t;

    bank_t b_d, b_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        b_d = b_q;
        if (rs_clr) begin
            b_d.cfg = b_q.cfg & ~RS_MASK;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_CFG:  b_d.cfg  = (wr_data & ~(RV_MASK | RS_MASK)) | (b_q.cfg & RV_MASK);
                SEL_OFS:  b_d.ofs  = wr_data;
                SEL_GAIN: b_d.gain = wr_data;
                SEL_CHAN: b_d.chan = wr_data;
                default:  b_d.cfg  = b_q.cfg;
            endcase
        end
        if (rd_en) begin
            unique case (sel)
                SEL_CFG:  b_d.rd = b_q.cfg;
                SEL_OFS:  b_d.rd = b_q.ofs;
                SEL_GAIN: b_d.rd = b_q.gain;
                SEL_CHAN: b_d.rd = b_q.chan;
                default:  b_d.rd = b_q.rd;
            endcase
            if (sel == SEL_CFG && !por_load) b_d.cfg = b_d.cfg & ~RV_MASK;
        end
        if (por_load || sw_load) begin
            b_d.cfg  = sw_load ? (CFG_DEF | RS_MASK) : CFG_DEF;
            b_d.ofs  = OFS_DEF;
            b_d.gain = GAIN_DEF;
            b_d.chan = CHAN_DEF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.cfg  <= CFG_DEF;
            b_q.ofs  <= OFS_DEF;
            b_q.gain <= GAIN_DEF;
            b_q.chan <= CHAN_DEF;
            b_q.rd   <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_data = b_q.rd;

    p_rv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        por_load |=> b_q.cfg[RV_BIT]);
    p_rv_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_CFG && !por_load && !sw_load) |=> !b_q.cfg[RV_BIT]);
    p_sw_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> (b_q.cfg == (CFG_DEF | RS_MASK)) && (b_q.gain == GAIN_DEF)
                    && (b_q.ofs == OFS_DEF) && (b_q.chan == CHAN_DEF));
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !sw_load && !por_load) |=> $stable(b_q.ofs) && $stable(b_q.gain)
                                              && $stable(b_q.chan));
    p_rs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rs_clr |=> !b_q.cfg[RS_BIT]);
endmodule

// File: rtl/osc_rst_ctrl.sv
module osc_rst_ctrl
    import osc_rst_pkg::*;
#(
    parameter int TERM_CNT    = 2006,
    parameter int CNT_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          osc_started,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          port_rst,
    output logic          cmd_mode
);
    typedef struct packed {
        rst_state_e st;
    } ctl_t;

    ctl_t c_d, c_q;
    logic osc_ok;
    logic settle_done;
    logic cfg_wr;
    logic sw_req;
    logic rs_clr;
    logic wr_ok;
    logic por_load;

    osc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .din   (osc_started),
        .dout  (osc_ok)
    );

    osc_rst_timer #(.TERM_CNT(TERM_CNT), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (por_n),
        .en    (c_q.st == ST_SETTLE),
        .done  (settle_done)
    );

    assign cfg_wr   = wr_en && (reg_sel_e'(addr) == SEL_CFG);
    assign sw_req   = (c_q.st == ST_CMD) && cfg_wr && wr_data[RS_BIT];
    assign rs_clr   = (c_q.st == ST_SWRST) && cfg_wr && !wr_data[RS_BIT];
    assign wr_ok    = (c_q.st == ST_CMD) && wr_en && !sw_req;
    assign por_load = (c_q.st == ST_HOLD) || (c_q.st == ST_SETTLE);

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_HOLD:   if (osc_ok)      c_d.st = ST_SETTLE;
            ST_SETTLE: if (settle_done) c_d.st = ST_CMD;
            ST_CMD:    if (sw_req)      c_d.st = ST_SWRST;
            ST_SWRST:  if (rs_clr)      c_d.st = ST_CMD;
            default:                    c_d.st = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) c_q.st <= ST_HOLD;
        else        c_q <= c_d;
    end

    osc_rst_regs u_regs (
        .clk      (clk),
        .rst_n    (por_n),
        .por_load (por_load),
        .sw_load  (sw_req),
        .rs_clr   (rs_clr),
        .wr_ok    (wr_ok),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

    assign busy     = (c_q.st != ST_CMD);
    assign port_rst = por_load;
    assign cmd_mode = (c_q.st == ST_CMD);

    p_hold_busy_r1: assert property (@(posedge clk) disable iff (!por_n)
        port_rst |-> (busy && !cmd_mode));
    p_settle_end_r2: assert property (@(posedge clk) disable iff (!por_n)
        $fell(port_rst) |-> cmd_mode);
    p_swreq_no_settle_r7: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_mode && wr_en && addr == SEL_CFG && wr_data[RS_BIT]) |=> (busy && !port_rst));
    p_rs_exit_r9: assert property (@(posedge clk) disable iff (!por_n)
        (busy && !port_rst && wr_en && addr == SEL_CFG && !wr_data[RS_BIT]) |=> cmd_mode);
endmodule

// File: tb/osc_rst_ctrl_bench.sv
module osc_rst_ctrl_bench;
    localparam int TERM = 2006;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        osc_started = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [23:0] wr_data = '0;
    logic [23:0] rd_data;
    logic        busy, port_rst, cmd_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [23:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    logic  pend = 1'b0;

    osc_rst_ctrl #(.TERM_CNT(TERM)) u_osc_rst_ctrl (
        .clk(clk), .por_n(por_n), .osc_started(osc_started),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .port_rst(port_rst), .cmd_mode(cmd_mode)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) pend <= rd_en;

    always @(negedge clk) begin
        if (pend) begin
            if (sb.size() == 0) begin
                chk(rd_data, 24'hxxxxxx, "R5 unexpected read");
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(rd_data, it.exp, it.tag);
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [23:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        rd_en = 1'b1;
        addr  = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic flags(input logic b, input logic p, input logic c, input string tag);
        chk({21'd0, busy, port_rst, cmd_mode}, {21'd0, b, p, c}, tag);
    endtask

    initial begin
        @(negedge clk);
        flags(1, 1, 0, "R1 in por");
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (20) @(negedge clk);
        flags(1, 1, 0, "R1 hold without osc");
        rd(2'd0, 24'h000040, "R4 rv during hold");
        rd(2'd0, 24'h000040, "R4 rv not cleared in hold");

        osc_started = 1'b1;
        repeat (100) @(posedge clk);
        @(negedge clk);
        rd(2'd0, 24'h000040, "R4 rv during settle");
        repeat (TERM + 2 - 101) @(posedge clk);
        @(negedge clk);
        flags(1, 1, 0, "R2 still held at last edge");
        @(posedge clk);
        @(negedge clk);
        flags(0, 0, 1, "R2 released");

        rd(2'd0, 24'h000040, "R5 first cfg read");
        rd(2'd0, 24'h000000, "R5 rv cleared");
        rd(2'd1, 24'h000000, "R3 offset default");
        rd(2'd2, 24'h400000, "R3 gain default");
        rd(2'd3, 24'h000000, "R3 chan default");

        wr(2'd1, 24'h123456);
        wr(2'd2, 24'h0ABCDE);
        wr(2'd3, 24'h00F00F);
        wr(2'd0, 24'hFFFF3F);
        rd(2'd1, 24'h123456, "R6 offset write");
        rd(2'd2, 24'h0ABCDE, "R6 gain write");
        rd(2'd3, 24'h00F00F, "R6 chan write");
        rd(2'd0, 24'hFFFF3F, "R6 cfg write");
        wr(2'd0, 24'h000040);
        rd(2'd0, 24'h000000, "R6 rv read-only");

        wr(2'd0, 24'h000080);
        flags(1, 0, 0, "R7 sw reset no settle");
        rd(2'd0, 24'h0000C0, "R7 cfg after sw reset");
        rd(2'd2, 24'h400000, "R7 gain reloaded");
        rd(2'd1, 24'h000000, "R7 offset reloaded");
        rd(2'd3, 24'h000000, "R7 chan reloaded");

        wr(2'd2, 24'h111111);
        wr(2'd1, 24'h222222);
        wr(2'd0, 24'h0000FF);
        flags(1, 0, 0, "R8 still busy");
        rd(2'd2, 24'h400000, "R8 gain write ignored");
        rd(2'd1, 24'h000000, "R8 offset write ignored");
        rd(2'd0, 24'h000080, "R8 cfg rs write ignored");

        wr(2'd0, 24'h00FF3F);
        flags(0, 0, 1, "R9 back in cmd");
        rd(2'd0, 24'h000000, "R9 other bits discarded");
        wr(2'd0, 24'h000011);
        rd(2'd0, 24'h000011, "R9 rewrite after exit");

        repeat (3) @(negedge clk);
        chk(24'(sb.size()), 24'd0, "R5 all reads returned");
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule